// File: doc/BRIEF.md
# Masked Composite-Field AES Substitution Unit

This block performs the AES byte substitution without ever forming the plain byte inside its datapath. The caller presents the byte already XORed with an 8-bit input mask, the mask itself, and sixteen bits of fresh randomness split into four nibbles. The block returns the substituted byte under a new output mask and reports that mask, so the surrounding round can keep working on shares.

Inside, the masked byte and its mask are each moved by one linear isomorphism into a pair of 4-bit field elements over GF((2^4)^2). The norm of the element and the two output halves are built from small 4-bit lookups, meaning square-and-scale, square and product, joined by XORs. Each masked product is expanded into its four share cross terms, and the fresh mask is XORed in first. The 4-bit inverse is a lookup addressed by the masked value together with its input and output masks. The two result halves then pass through the inverse isomorphism and the AES affine step. The output mask is the linear part of that same path applied to the two outer fresh nibbles. All tables and both mapping matrices are derived at elaboration by constant functions, which search for the subfield constant and for a root of the AES polynomial.

A single register stage holds the result, so a valid input is answered exactly one clock later.

Top module: `masked_sbox_cf`

## Requirements
- R1: For every input byte x, input mask m and fresh value, the registered outputs satisfy sbox_o XOR mask_o = S(x), where S is the AES S-box (GF(2^8) inverse under x^8+x^4+x^3+x+1, with 0 mapped to 0, followed by the affine step with constant 0x63), and the input presented is mbyte_i = x XOR m.
- R2: vld_o equals the vld_i sampled at the previous rising clock edge, and the result of a valid input appears on sbox_o and mask_o in that same cycle.
- R3: While vld_i is low, sbox_o and mask_o keep their values whatever the other inputs do.
- R4: While rst_n is low, vld_o, sbox_o and mask_o are zero.
- R5: mask_o depends only on fresh_i[15:8] (nibble [11:8] masks the high result half, [15:12] the low half). It is zero when those bits are zero and does not change with the input byte or the input mask.
- R6: The inner fresh nibbles, fresh_i[3:0] masking the norm and fresh_i[7:4] masking its inverse, have no effect on sbox_o or mask_o.
- R7: For fixed x and fixed fresh_i, sbox_o does not depend on the input mask m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Input byte and masks are valid this cycle |
| mbyte_i | input | 8 | Masked input byte x XOR m |
| mask_i | input | 8 | Input mask m |
| fresh_i | input | 16 | Fresh nibbles: [3:0] norm, [7:4] inverse, [11:8] high out, [15:12] low out |
| vld_o | output | 1 | Registered valid, one cycle after vld_i |
| sbox_o | output | 8 | Masked substituted byte S(x) XOR mask_o |
| mask_o | output | 8 | Output mask of sbox_o |

## Verification
The assertions assume that the caller drives vld_i to a known level on every clock after reset. The mask-stability property also assumes that a valid input whose outer fresh nibbles repeat those of the previous valid input must leave the output mask unchanged. The bench changes inputs only on falling edges and asserts vld_i in long runs, which exercises the back-to-back case. Between runs it drops vld_i while scrambling the byte, mask and fresh inputs, so the hold behaviour is tested against inputs that would otherwise alter the outputs. The arithmetic identity itself is compared against a reference S-box computed in the bench by exponentiation. That comparison covers all 256 bytes under rolling masks, all 256 input masks for one byte, and all inner fresh combinations.

// File: rtl/masked_sbox_cf.sv
module masked_sbox_cf (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        vld_i,
  input  logic [7:0]  mbyte_i,
  input  logic [7:0]  mask_i,
  input  logic [15:0] fresh_i,
  output logic        vld_o,
  output logic [7:0]  sbox_o,
  output logic [7:0]  mask_o
);

  function automatic logic [3:0] gf4_mul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] r, s;
    r = '0;
    s = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) r = r ^ s;
      s = {s[2:0], 1'b0} ^ (s[3] ? 4'h3 : 4'h0);
    end
    return r;
  endfunction

  function automatic logic [3:0] gf4_sq(input logic [3:0] a);
    return gf4_mul(a, a);
  endfunction

  function automatic logic [3:0] gf4_inv(input logic [3:0] a);
    logic [3:0] a2, a4, a8;
    a2 = gf4_sq(a);
    a4 = gf4_sq(a2);
    a8 = gf4_sq(a4);
    return gf4_mul(gf4_mul(a8, a4), a2);
  endfunction

  function automatic logic [3:0] find_p0();
    logic [3:0] res;
    logic ok;
    res = 4'h0;
    for (int p = 15; p > 0; p--) begin
      ok = 1'b1;
      for (int t = 0; t < 16; t++)
        if ((gf4_sq(4'(t)) ^ 4'(t)) == 4'(p)) ok = 1'b0;
      if (ok) res = 4'(p);
    end
    return res;
  endfunction

  localparam logic [3:0] P0 = find_p0();

  function automatic logic [7:0] cf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [3:0] hh;
    hh = gf4_mul(a[7:4], b[7:4]);
    return {hh ^ gf4_mul(a[7:4], b[3:0]) ^ gf4_mul(a[3:0], b[7:4]),
            gf4_mul(hh, P0) ^ gf4_mul(a[3:0], b[3:0])};
  endfunction

  function automatic logic [7:0] find_beta();
    logic [7:0] res, pw [9];
    res = 8'h0;
    for (int c = 255; c > 1; c--) begin
      pw[0] = 8'h01;
      for (int i = 1; i < 9; i++) pw[i] = cf_mul(pw[i-1], 8'(c));
      if ((pw[8] ^ pw[4] ^ pw[3] ^ pw[1] ^ pw[0]) == 8'h00) res = 8'(c);
    end
    return res;
  endfunction

  localparam logic [7:0] BETA = find_beta();

  function automatic logic [7:0] lin_apply(input logic [7:0][7:0] cols, input logic [7:0] v);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < 8; i++)
      if (v[i]) r = r ^ cols[i];
    return r;
  endfunction

  function automatic logic [7:0][7:0] build_fwd();
    logic [7:0][7:0] cols;
    logic [7:0] p;
    p = 8'h01;
    for (int i = 0; i < 8; i++) begin
      cols[i] = p;
      p = cf_mul(p, BETA);
    end
    return cols;
  endfunction

  localparam logic [7:0][7:0] FWD = build_fwd();

  function automatic logic [7:0][7:0] build_bwd();
    logic [7:0][7:0] cols;
    cols = '0;
    for (int j = 0; j < 8; j++)
      for (int v = 0; v < 256; v++)
        if (lin_apply(FWD, 8'(v)) == (8'h01 << j)) cols[j] = 8'(v);
    return cols;
  endfunction

  localparam logic [7:0][7:0] BWD = build_bwd();

  function automatic logic [7:0] aff_lin(input logic [7:0] b);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]};
  endfunction

  function automatic logic [3:0] t_sqk(input logic [3:0] v);
    return gf4_mul(gf4_sq(v), P0);
  endfunction

  function automatic logic [3:0] t_inv(input logic [3:0] dm, input logic [3:0] min,
                                       input logic [3:0] mout);
    return gf4_inv(dm ^ min) ^ mout;
  endfunction

  logic [7:0] cx, cm, res_m, res_k;
  logic [3:0] ah, al, mh, ml, ra, rb, rc, rd, sm, ms, d_m, i_m, oh_m, ol_m;

  assign cx = lin_apply(FWD, mbyte_i);
  assign cm = lin_apply(FWD, mask_i);
  assign {ah, al} = cx;
  assign {mh, ml} = cm;
  assign {rd, rc, rb, ra} = fresh_i;
  assign sm = ah ^ al;
  assign ms = mh ^ ml;

  assign d_m = ra ^ t_sqk(ah) ^ t_sqk(mh) ^ gf4_sq(al) ^ gf4_sq(ml)
             ^ gf4_mul(ah, al) ^ gf4_mul(ah, ml) ^ gf4_mul(mh, al) ^ gf4_mul(mh, ml);
  assign i_m = t_inv(d_m, ra, rb);
  assign oh_m = rc ^ gf4_mul(ah, i_m) ^ gf4_mul(ah, rb) ^ gf4_mul(mh, i_m) ^ gf4_mul(mh, rb);
  assign ol_m = rd ^ gf4_mul(sm, i_m) ^ gf4_mul(sm, rb) ^ gf4_mul(ms, i_m) ^ gf4_mul(ms, rb);

  assign res_m = aff_lin(lin_apply(BWD, {oh_m, ol_m})) ^ 8'h63;
  assign res_k = aff_lin(lin_apply(BWD, {rc, rd}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      sbox_o <= '0;
      mask_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        sbox_o <= res_m;
        mask_o <= res_k;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> vld_o);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !vld_o);
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> ($stable(sbox_o) && $stable(mask_o)));
  a_r5_zero_outer_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && fresh_i[15:8] == 8'h00) |=> mask_o == 8'h00);
  a_r5_mask_tracks_outer: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && vld_o && $stable(fresh_i[15:8])) |=> $stable(mask_o));

endmodule

// File: tb/masked_sbox_cf_test.sv
module masked_sbox_cf_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld_i = 1'b0;
  logic [7:0]  mbyte_i = '0, mask_i = '0;
  logic [15:0] fresh_i = '0;
  logic        vld_o;
  logic [7:0]  sbox_o, mask_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  masked_sbox_cf uut (.clk(clk), .rst_n(rst_n), .vld_i(vld_i), .mbyte_i(mbyte_i),
    .mask_i(mask_i), .fresh_i(fresh_i), .vld_o(vld_o), .sbox_o(sbox_o), .mask_o(mask_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ a;
      a = {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_sbox(input logic [7:0] x);
    logic [7:0] inv = 8'h01;
    logic [7:0] s;
    for (int i = 0; i < 254; i++) inv = gmul(inv, x);
    s = 8'h63;
    for (int i = 0; i < 8; i++)
      s[i] = s[i] ^ inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] x, input logic [7:0] m, input logic [15:0] f);
    vld_i   = 1'b1;
    mbyte_i = x ^ m;
    mask_i  = m;
    fresh_i = f;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] ref_out, ref_mask;
    logic [15:0] f;
    @(negedge clk);
    check(vld_o == 1'b0 && sbox_o == 8'h00 && mask_o == 8'h00, "R4 reset outputs",
          {vld_o, sbox_o, mask_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    f = 16'hace1;
    for (int x = 0; x < 256; x++) begin
      apply(8'(x), 8'(x * 37 + 11), f);
      check((sbox_o ^ mask_o) == ref_sbox(8'(x)), "R1 all bytes", sbox_o ^ mask_o,
            ref_sbox(8'(x)));
      check(vld_o == 1'b1, "R2 valid latency", vld_o, 1);
      f = {f[14:0], f[15] ^ f[13] ^ f[12] ^ f[10]};
    end

    apply(8'h53, 8'h00, 16'h9c5a);
    ref_out = sbox_o;
    for (int m = 0; m < 256; m++) begin
      apply(8'h53, 8'(m), 16'h9c5a);
      check(sbox_o == ref_out, "R7 input mask independence", sbox_o, ref_out);
      check((sbox_o ^ mask_o) == ref_sbox(8'h53), "R1 mask sweep", sbox_o ^ mask_o,
            ref_sbox(8'h53));
    end

    apply(8'hc4, 8'h3b, 16'h7e00);
    ref_out = sbox_o;
    ref_mask = mask_o;
    for (int r = 0; r < 256; r++) begin
      apply(8'hc4, 8'h3b, {8'h7e, 8'(r)});
      check(sbox_o == ref_out && mask_o == ref_mask, "R6 inner fresh no effect",
            {sbox_o, mask_o}, {ref_out, ref_mask});
    end

    for (int x = 0; x < 256; x += 5) begin
      apply(8'(x), 8'(x ^ 8'h5a), 16'h00f3);
      check(mask_o == 8'h00, "R5 zero outer mask", mask_o, 0);
      check(sbox_o == ref_sbox(8'(x)), "R1 zero outer mask", sbox_o, ref_sbox(8'(x)));
    end

    apply(8'h00, 8'h00, 16'h4d21);
    ref_mask = mask_o;
    for (int x = 0; x < 256; x += 3) begin
      apply(8'(x), 8'(255 - x), {8'h4d, 8'(x * 7)});
      check(mask_o == ref_mask, "R5 mask independent of byte", mask_o, ref_mask);
    end

    apply(8'h01, 8'h77, 16'h1234);
    ref_out = sbox_o;
    ref_mask = mask_o;
    vld_i = 1'b0;
    mbyte_i = 8'hff;
    mask_i = 8'h0f;
    fresh_i = 16'hffff;
    @(negedge clk);
    check(vld_o == 1'b0, "R2 valid drops", vld_o, 0);
    for (int k = 0; k < 3; k++) begin
      mbyte_i = mbyte_i + 8'd29;
      fresh_i = fresh_i ^ 16'h5555;
      @(negedge clk);
      check(sbox_o == ref_out && mask_o == ref_mask, "R3 hold while idle",
            {sbox_o, mask_o}, {ref_out, ref_mask});
    end
    check((ref_out ^ ref_mask) == ref_sbox(8'h01), "R1 held value", ref_out ^ ref_mask,
          ref_sbox(8'h01));

    apply(8'h10, 8'h22, 16'h0000);
    rst_n = 1'b0;
    #1;
    check(vld_o == 1'b0 && sbox_o == 8'h00 && mask_o == 8'h00, "R4 async reset",
          {vld_o, sbox_o, mask_o}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule